// File: doc/BRIEF.md
# Split-Tenure Bus Master

This block sits between a processor core and a shared system bus on which the address phase and the data phase are two separate tenures. Each one has its own arbitration, transfer and termination. The core hands over one transfer at a time through a valid/ready handshake. A transfer is a read or a write, a single beat or a four-beat burst, or an address-only operation such as a cache-block zero.

For each accepted transfer the block requests the address bus. It waits for a grant that counts only while no other master holds the address bus. It then drives the address, the transfer attributes and byte parity for one tenure. That tenure ends with an acknowledge, or with a retry that forces the whole address tenure to start over. A transfer that carries data then gets its own data tenure. The block waits for a qualified data grant, moves one 64-bit beat on each beat termination, and reports completion to the core with a done pulse and a sticky parity-error flag.

The address bus is given up as soon as the address tenure ends. The address tenure of the next transfer can therefore run while the current data tenure is still moving beats. Completions always reach the core in the order the requests were accepted.

Top module: `split_bus_master`

## Requirements
- R1: After reset, req_ready is 1 and bus_req, abusy_out, dbusy_out, xfer_start, done and done_err are all 0.
- R2: In the cycle after a request is accepted, bus_req is 1. It stays 1 until a clock edge at which bus_grant is 1 and abusy_in is 0. A grant seen while abusy_in is 1 is not taken: abusy_out stays 0 and bus_req stays 1.
- R3: In the cycle after a qualified address grant, xfer_start is 1 for exactly one cycle. abusy_out is 1 and stays 1 through the cycle in which addr_ack or addr_retry arrives. While abusy_out is 1, addr_out carries the request address, and attr_write, attr_burst and attr_nodata carry the request's write, burst and address-only flags.
- R4: Parity is odd and taken per byte. Bit i of addr_par covers addr_out[8i+7:8i], and bit i of wdata_par covers wdata_out[8i+7:8i]. Each parity bit is 1 exactly when its byte holds an even number of ones.
- R5: When addr_retry is 1 during an address tenure, it wins over addr_ack. In the next cycle abusy_out is 0 and bus_req is 1, and the address tenure is repeated with a new xfer_start.
- R6: An address-only request (req_nodata=1) ends with a done pulse after its address tenure. It never takes the data bus: dbusy_out stays 0 and there are no beats.
- R7: A waiting data tenure takes the data bus only at a clock edge where dgrant is 1 and dbusy_in is 0. dbusy_out is then 1 from the next cycle until the final beat termination.
- R8: A single transfer (req_burst=0) moves one beat and a burst moves exactly 4 beats. Each beat advances only on a cycle with beat_ack=1 while dbusy_out is 1. The done pulse follows the final beat.
- R9: During a write data tenure, wdata_en is 1 and wdata_out equals wr_data. wr_next is 1 in each cycle where a beat is terminated, and the core then presents the next beat on wr_data.
- R10: For a read, rd_valid pulses in the cycle after each beat termination, and rd_data holds the rdata_in value sampled with that termination.
- R11: done_err is 1 with a transfer's done pulse when addr_perr was seen during any of its address tenures, or data_perr during its data tenure. Otherwise it is 0.
- R12: A new request can be accepted, and its address tenure can run, while an earlier data tenure is still active. done pulses come in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst |
| req_nodata | input | 1 | 1 = address-only operation |
| wr_data | input | DW | Current write beat from core |
| wr_next | output | 1 | Write beat consumed, present the next |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DW | Read beat data |
| done | output | 1 | Transfer complete pulse |
| done_err | output | 1 | Parity error seen on the completed transfer |
| bus_req | output | 1 | Address bus request |
| bus_grant | input | 1 | Address bus grant |
| abusy_in | input | 1 | Another master holds the address bus |
| abusy_out | output | 1 | This block holds the address bus |
| xfer_start | output | 1 | First cycle of an address transfer |
| addr_out | output | AW | Address driven on the bus |
| addr_par | output | AW/8 | Odd byte parity of addr_out |
| attr_write | output | 1 | Attribute: write |
| attr_burst | output | 1 | Attribute: burst |
| attr_nodata | output | 1 | Attribute: address-only |
| addr_ack | input | 1 | Address tenure completed |
| addr_retry | input | 1 | Address tenure must be repeated |
| addr_perr | input | 1 | Address parity error reported by the system |
| dgrant | input | 1 | Data bus grant |
| dbusy_in | input | 1 | Another master holds the data bus |
| dbusy_out | output | 1 | This block holds the data bus |
| wdata_en | output | 1 | Write data driven |
| wdata_out | output | DW | Write data on the bus |
| wdata_par | output | DW/8 | Odd byte parity of wdata_out |
| rdata_in | input | DW | Read data from the bus |
| beat_ack | input | 1 | Data beat termination |
| data_perr | input | 1 | Data parity error reported by the system |

## Verification
The bench holds grants while the matching busy line is high. A master that ignored the busy qualification would grab an occupied bus and raise its own busy line a cycle early. It retries one address tenure twice before acknowledging it. A design that let the acknowledge win, or that failed to go back to arbitration, would show the wrong number of transfer starts or complete a tenure that should have been repeated. Bursts are paced with gaps between beat terminations, so a beat counter that advanced without a termination would deliver too few or misplaced beats. A burst read, a write and an address-only operation are then overlapped with a running data tenure. Completions that came out of order, or a sticky error that leaked from one transfer into the next, would show up as a mismatch in the scoreboard.

// File: rtl/split_bus_master.sv
`timescale 1ns/1ps
module split_bus_master #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic          req_nodata,
  input  logic [DW-1:0] wr_data,
  output logic          wr_next,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          done_err,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          abusy_in,
  output logic          abusy_out,
  output logic          xfer_start,
  output logic [AW-1:0] addr_out,
  output logic [AW/8-1:0] addr_par,
  output logic          attr_write,
  output logic          attr_burst,
  output logic          attr_nodata,
  input  logic          addr_ack,
  input  logic          addr_retry,
  input  logic          addr_perr,
  input  logic          dgrant,
  input  logic          dbusy_in,
  output logic          dbusy_out,
  output logic          wdata_en,
  output logic [DW-1:0] wdata_out,
  output logic [DW/8-1:0] wdata_par,
  input  logic [DW-1:0] rdata_in,
  input  logic          beat_ack,
  input  logic          data_perr
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int AP = AW / 8;
  localparam int DP = DW / 8;

  typedef enum logic [1:0] {A_IDLE, A_ARB, A_XFER} a_state_t;
  a_state_t a_st;

  logic [AW-1:0] a_addr_q;
  logic a_wr_q, a_bst_q, a_nod_q, a_err_q, a_first;
  logic p_v, p_wr, p_bst, p_nod, p_err;
  logic d_act, d_own, d_wr, d_bst, d_err;
  logic [CW-1:0] d_beat;
  logic a_qual, a_fin, d_qual, d_last, beat_ev;

  assign req_ready   = (a_st == A_IDLE) && !p_v;
  assign bus_req     = (a_st == A_ARB);
  assign abusy_out   = (a_st == A_XFER);
  assign xfer_start  = a_first;
  assign addr_out    = abusy_out ? a_addr_q : '0;
  assign attr_write  = abusy_out && a_wr_q;
  assign attr_burst  = abusy_out && a_bst_q;
  assign attr_nodata = abusy_out && a_nod_q;
  assign a_qual      = bus_req && bus_grant && !abusy_in;
  assign a_fin       = abusy_out && addr_ack && !addr_retry;

  assign d_qual    = d_act && !d_own && dgrant && !dbusy_in;
  assign beat_ev   = d_own && beat_ack;
  assign d_last    = d_bst ? (d_beat == CW'(BEATS - 1)) : 1'b1;
  assign dbusy_out = d_own;
  assign wdata_en  = d_own && d_wr;
  assign wdata_out = wdata_en ? wr_data : '0;
  assign wr_next   = beat_ev && d_wr;

  for (genvar i = 0; i < AP; i++) begin : g_apar
    assign addr_par[i] = ~^addr_out[8*i +: 8];
  end
  for (genvar i = 0; i < DP; i++) begin : g_dpar
    assign wdata_par[i] = ~^wdata_out[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_st     <= A_IDLE;
      a_addr_q <= '0;
      a_wr_q   <= 1'b0;
      a_bst_q  <= 1'b0;
      a_nod_q  <= 1'b0;
      a_err_q  <= 1'b0;
      a_first  <= 1'b0;
    end else begin
      a_first <= 1'b0;
      case (a_st)
        A_IDLE: if (req_valid && req_ready) begin
          a_st     <= A_ARB;
          a_addr_q <= req_addr;
          a_wr_q   <= req_write && !req_nodata;
          a_bst_q  <= req_burst && !req_nodata;
          a_nod_q  <= req_nodata;
          a_err_q  <= 1'b0;
        end
        A_ARB: if (a_qual) begin
          a_st    <= A_XFER;
          a_first <= 1'b1;
        end
        A_XFER: begin
          if (addr_perr) a_err_q <= 1'b1;
          if (addr_retry)    a_st <= A_ARB;
          else if (addr_ack) a_st <= A_IDLE;
        end
        default: a_st <= A_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v <= 1'b0; p_wr <= 1'b0; p_bst <= 1'b0; p_nod <= 1'b0; p_err <= 1'b0;
    end else if (a_fin) begin
      p_v   <= 1'b1;
      p_wr  <= a_wr_q;
      p_bst <= a_bst_q;
      p_nod <= a_nod_q;
      p_err <= a_err_q || addr_perr;
    end else if (p_v && !d_act) begin
      p_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_act <= 1'b0; d_own <= 1'b0; d_wr <= 1'b0; d_bst <= 1'b0; d_err <= 1'b0;
      d_beat <= '0; done <= 1'b0; done_err <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (p_v && !d_act) begin
        if (p_nod) begin
          done     <= 1'b1;
          done_err <= p_err;
        end else begin
          d_act  <= 1'b1;
          d_wr   <= p_wr;
          d_bst  <= p_bst;
          d_err  <= p_err;
          d_beat <= '0;
        end
      end
      if (d_qual) d_own <= 1'b1;
      if (d_own && data_perr) d_err <= 1'b1;
      if (beat_ev) begin
        d_beat <= d_beat + 1'b1;
        if (!d_wr) begin
          rd_valid <= 1'b1;
          rd_data  <= rdata_in;
        end
        if (d_last) begin
          d_act    <= 1'b0;
          d_own    <= 1'b0;
          done     <= 1'b1;
          done_err <= d_err || data_perr;
        end
      end
    end
  end

  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_req);  // R2
  AST_ADDR_QUAL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abusy_out) |-> $past(bus_grant && !abusy_in));  // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);  // R3
  AST_RETRY_REARB: assert property (@(posedge clk) disable iff (!rst_n)
    (abusy_out && addr_retry) |=> (bus_req && !abusy_out));  // R5
  AST_DATA_QUAL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbusy_out) |-> $past(dgrant && !dbusy_in));  // R7
  AST_RD_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(beat_ack && dbusy_out));  // R10
endmodule

// File: tb/split_bus_master_tb.sv
`timescale 1ns/1ps
module split_bus_master_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] addr;
    bit wr, bst, nod, ape, dpe, gap;
    logic [63:0] wb;
    int rty;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_burst = 0, req_nodata = 0;
  logic [31:0] req_addr = '0;
  logic [63:0] wr_data = '0, rdata_in = '0;
  logic bus_grant = 0, abusy_in = 0, addr_ack = 0, addr_retry = 0, addr_perr = 0;
  logic dgrant = 0, dbusy_in = 0, beat_ack = 0, data_perr = 0;
  logic req_ready, wr_next, rd_valid, done, done_err, bus_req, abusy_out, xfer_start;
  logic attr_write, attr_burst, attr_nodata, dbusy_out, wdata_en;
  logic [63:0] rd_data, wdata_out;
  logic [31:0] addr_out;
  logic [3:0] addr_par;
  logic [7:0] wdata_par;

  int n_chk = 0, n_bad = 0;
  int abusy_hold = 0, dbusy_hold = 0, dbc = 0, ovl_seen = 0, r2_hits = 0, r7_hits = 0;
  item_t exp_q[$], aq[$], dq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  split_bus_master dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write, .req_burst, .req_nodata,
    .wr_data, .wr_next, .rd_valid, .rd_data, .done, .done_err, .bus_req, .bus_grant,
    .abusy_in, .abusy_out, .xfer_start, .addr_out, .addr_par, .attr_write, .attr_burst,
    .attr_nodata, .addr_ack, .addr_retry, .addr_perr, .dgrant, .dbusy_in, .dbusy_out,
    .wdata_en, .wdata_out, .wdata_par, .rdata_in, .beat_ack, .data_perr);

  task automatic chk(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [3:0] apar(logic [31:0] a);
    for (int i = 0; i < 4; i++) apar[i] = ~^a[8*i +: 8];
  endfunction
  function automatic logic [7:0] dpar(logic [63:0] d);
    for (int i = 0; i < 8; i++) dpar[i] = ~^d[8*i +: 8];
  endfunction
  function automatic logic [63:0] rpat(logic [31:0] a, int b);
    return {a ^ 32'h5A5A_0000, (32'(b) * 32'h0101_0101) ^ 32'h0000_00C3};
  endfunction
  function automatic int nbeats(item_t it);
    return it.nod ? 0 : (it.bst ? 4 : 1);
  endfunction
  function automatic item_t mk(logic [31:0] a, bit wr, bit bst, bit nod, int rty,
                               bit ape, bit dpe, bit gap);
    item_t it;
    it.addr = a; it.wr = wr; it.bst = bst; it.nod = nod; it.rty = rty;
    it.ape = ape; it.dpe = dpe; it.gap = gap;
    it.wb = {a, ~a} ^ 64'h1234_5678_9ABC_DEF0;
    return it;
  endfunction

  task automatic issue(input item_t it);
    @(negedge clk);
    req_valid = 1; req_addr = it.addr; req_write = it.wr; req_burst = it.bst; req_nodata = it.nod;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_q.push_back(it);
    aq.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : addr_model
    bit g_n = 0, k_n = 0, r_n = 0, e_n = 0, blk = 0, rchk = 0, tsp = 0;
    int tsn = 0;
    item_t h;
    forever begin
      @(negedge clk);
      bus_grant = g_n; abusy_in = (abusy_hold > 0);
      if (abusy_hold > 0) abusy_hold--;
      addr_ack = k_n; addr_retry = r_n; addr_perr = e_n;
      #1;
      if (blk) begin
        r2_hits++;
        chk(!abusy_out && bus_req, "R2",
            $sformatf("busy grant taken: abusy_out=%0b bus_req=%0b exp 0/1", abusy_out, bus_req));
      end
      blk = bus_grant && abusy_in && bus_req;
      if (rchk) chk(!abusy_out && bus_req, "R5",
            $sformatf("after retry abusy_out=%0b bus_req=%0b exp 0/1", abusy_out, bus_req));
      rchk = addr_retry;
      if (tsp) chk(!xfer_start && abusy_out, "R3",
            $sformatf("tenure hold: xfer_start=%0b abusy_out=%0b exp 0/1", xfer_start, abusy_out));
      tsp = xfer_start;
      if (addr_ack && !addr_retry && aq.size() > 0) begin
        h = aq.pop_front();
        chk(tsn == h.rty + 1, "R5", $sformatf("xfer_start count %0d exp %0d", tsn, h.rty + 1));
        tsn = 0;
        if (!h.nod) dq.push_back(h);
      end
      k_n = 0; r_n = 0; e_n = 0;
      if (xfer_start) begin
        if (aq.size() == 0) chk(0, "R3", "xfer_start with no request got 1 exp 0");
        else begin
          h = aq[0];
          tsn++;
          if (dbusy_out) ovl_seen++;
          chk(abusy_out && addr_out == h.addr && attr_write == h.wr && attr_burst == h.bst
              && attr_nodata == h.nod, "R3",
              $sformatf("addr=%h attrs=%0b%0b%0b exp addr=%h attrs=%0b%0b%0b", addr_out,
                        attr_write, attr_burst, attr_nodata, h.addr, h.wr, h.bst, h.nod));
          chk(addr_par == apar(h.addr), "R4",
              $sformatf("addr_par=%h exp %h", addr_par, apar(h.addr)));
          if (tsn <= h.rty) r_n = 1;
          else begin k_n = 1; e_n = h.ape; end
        end
      end
      g_n = bus_req;
    end
  end

  initial begin : data_model
    bit dg_n = 0, ba_n = 0, dpe_n = 0, blk = 0, active = 0, tog = 0, fin = 0;
    logic [63:0] rd_n = '0, ew;
    int b = 0;
    item_t cur;
    forever begin
      @(negedge clk);
      dgrant = dg_n; dbusy_in = (dbusy_hold > 0);
      if (dbusy_hold > 0) dbusy_hold--;
      beat_ack = ba_n; rdata_in = rd_n; data_perr = dpe_n;
      #1;
      if (blk) begin
        r7_hits++;
        chk(!dbusy_out, "R7", $sformatf("busy data grant taken: dbusy_out=%0b exp 0", dbusy_out));
      end
      blk = dgrant && dbusy_in && !dbusy_out;
      if (dbusy_out) dbc++;
      fin = 0;
      if (beat_ack && active) begin
        if (cur.wr) begin
          ew = cur.wb + 64'(b);
          chk(wdata_en && wr_next && wdata_out == ew, "R9",
              $sformatf("wdata=%h en=%0b next=%0b exp %h 1 1", wdata_out, wdata_en, wr_next, ew));
          chk(wdata_par == dpar(ew), "R4", $sformatf("wdata_par=%h exp %h", wdata_par, dpar(ew)));
        end
        b++;
        if (b == nbeats(cur)) begin active = 0; fin = 1; end
      end
      if (dbusy_out && !active && !fin) begin
        if (dq.size() == 0) chk(0, "R6", "data bus owned with no data transfer: got 1 exp 0");
        else begin cur = dq.pop_front(); active = 1; b = 0; tog = 0; end
      end
      ba_n = 0; dpe_n = 0;
      if (active) begin
        if (cur.gap) begin tog = !tog; ba_n = tog; end
        else ba_n = 1;
        rd_n = rpat(cur.addr, b);
        dpe_n = ba_n && cur.dpe && (b == 0);
      end
      dg_n = !active && dq.size() > 0;
    end
  end

  initial begin : monitor
    logic [63:0] rb[$];
    int wc = 0;
    item_t e;
    bit eerr;
    forever begin
      @(negedge clk);
      wr_data = (exp_q.size() > 0) ? exp_q[0].wb + 64'(wc) : '0;
      #1;
      if (rd_valid) rb.push_back(rd_data);
      if (wr_next) wc++;
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R12", "unexpected done got 1 exp 0");
        else begin
          e = exp_q.pop_front();
          eerr = e.ape || (!e.nod && e.dpe);
          chk(done_err == eerr, "R11", $sformatf("done_err=%0b exp %0b addr %h", done_err, eerr, e.addr));
          if (e.wr) chk(wc == nbeats(e) && rb.size() == 0, "R8",
                        $sformatf("write beats %0d reads %0d exp %0d 0", wc, rb.size(), nbeats(e)));
          else begin
            chk(rb.size() == nbeats(e) && wc == 0, "R8/R6",
                $sformatf("read beats %0d exp %0d addr %h", rb.size(), nbeats(e), e.addr));
            for (int i = 0; i < rb.size() && i < nbeats(e); i++)
              chk(rb[i] == rpat(e.addr, i), "R10/R12",
                  $sformatf("beat %0d got %h exp %h", i, rb[i], rpat(e.addr, i)));
          end
          rb.delete();
          wc = 0;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run not finished, got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready == 1, "R1", $sformatf("req_ready=%0b exp 1", req_ready));
    chk(!bus_req && !abusy_out && !dbusy_out, "R1",
        $sformatf("bus_req=%0b abusy=%0b dbusy=%0b exp 0", bus_req, abusy_out, dbusy_out));
    chk(!done && !done_err && !xfer_start, "R1",
        $sformatf("done=%0b err=%0b start=%0b exp 0", done, done_err, xfer_start));

    issue(mk(32'h1000_0040, 0, 0, 0, 0, 0, 0, 0)); wait_idle();
    issue(mk(32'h2000_0080, 1, 0, 0, 0, 0, 0, 0)); wait_idle();
    issue(mk(32'h3000_0100, 0, 1, 0, 0, 0, 0, 1)); wait_idle();
    issue(mk(32'h4000_0200, 1, 1, 0, 0, 0, 0, 1)); wait_idle();
    d0 = dbc;
    issue(mk(32'h5000_0300, 0, 0, 1, 0, 0, 0, 0)); wait_idle();
    chk(dbc == d0, "R6", $sformatf("dbusy cycles during address-only %0d exp 0", dbc - d0));
    issue(mk(32'h6000_0400, 0, 1, 0, 2, 0, 0, 0)); wait_idle();
    abusy_hold = 5;
    issue(mk(32'h7000_0500, 1, 0, 0, 0, 0, 0, 0)); wait_idle();
    chk(r2_hits > 0, "R2", $sformatf("busy-grant cases seen %0d exp >0", r2_hits));
    issue(mk(32'h8000_0600, 0, 1, 0, 0, 0, 0, 0));
    dbusy_hold = 10;
    wait_idle();
    chk(r7_hits > 0, "R7", $sformatf("busy data grant cases seen %0d exp >0", r7_hits));
    issue(mk(32'h9000_0700, 1, 0, 0, 1, 1, 0, 0)); wait_idle();
    issue(mk(32'hA000_0800, 0, 1, 0, 0, 0, 1, 1)); wait_idle();
    issue(mk(32'hB000_0900, 0, 0, 0, 0, 0, 0, 0)); wait_idle();
    issue(mk(32'hC000_0A00, 0, 1, 0, 0, 0, 0, 1));
    issue(mk(32'hD000_0B00, 1, 0, 0, 0, 0, 0, 0));
    issue(mk(32'hE000_0C00, 0, 0, 1, 0, 1, 0, 0));
    issue(mk(32'hF000_0D00, 0, 0, 0, 0, 0, 0, 1));
    wait_idle();
    chk(ovl_seen > 0, "R12", $sformatf("address starts during data tenure %0d exp >0", ovl_seen));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule